// File: doc/BRIEF.md
# Random Frequency Hopping Controller

This block moves a system clock between operating points at random, irregular moments and writes a log record for every move. After an analysis run, each frequency step in a long recording can be found and undone from the log alone. It takes words from an entropy source. It keeps a word only if it names one of the operating points, and then drives that point's select code to an external clock generator. The clock generator sits outside the block; the block only presents the code and a matching nominal frequency in kHz.

How long the block stays on each point is also random. For each hop it draws a dwell length that falls between a lower and an upper bound set by the user. From the moment a trigger arms it, the block counts samples once per clock. Each time the code changes, it offers a record on a valid/ready port. The record holds the sample index at which the new code first appeared, and the new code. The block holds its next hop until that record has been taken, so no change can go unlogged.

The default table has 760 points. They are spaced evenly from 5 MHz up to just under 100 MHz. A dwell around four thousand samples gives roughly thirty thousand hops per long capture.

Top module: `hop_freq_ctrl`

## Requirements
- R1: While reset is low at a rising edge, the block returns to idle, with `freq_code_o` = 0, `sample_idx_o` = 0 and `log_valid_o` = 0.
- R2: Until `start_i` is seen high at a rising edge, the block stays idle: `sample_idx_o` stays 0, no record is offered and the code does not change. The edge that arms it leaves `sample_idx_o` at 0. After that edge, `sample_idx_o` rises by exactly one per clock.
- R3: In a code draw, the low `CODE_W` bits of `rnd_i` (10 bits by default) are taken as the candidate. A candidate below `N_POINTS` (760) becomes the new `freq_code_o`. A candidate of 760 or more is discarded, and the code stays unchanged.
- R4: `freq_khz_o` always equals 5000 + 125 × `freq_code_o`.
- R5: The new code and its record appear in the same cycle. In that first cycle, `log_valid_o` rises, `log_code_o` equals the new code, and `log_index_o` equals `sample_idx_o`.
- R6: While `log_valid_o` is high and `log_ready_i` is low, the record stays unchanged and no further hop takes place. The record is taken on the first rising edge at which `log_ready_i` is high.
- R7: The dwell draw is made in the cycle after the record is taken. Let span = max − min. The candidate is `rnd_i` ANDed with the smallest all-ones mask that covers span. A candidate greater than span is discarded and drawn again. An accepted candidate c gives a dwell of d = min + c. With no stalls, consecutive records are d + 4 samples apart, and every discarded or stalled cycle adds one sample to that spacing.
- R8: In a cycle where `rnd_valid_i` is low, no draw is made. Neither the code nor the dwell is taken from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Arms the block; only its first sighting matters |
| rnd_valid_i | input | 1 | `rnd_i` holds a fresh entropy word |
| rnd_i | input | RND_W | Entropy word |
| dwell_min_i | input | DWELL_W | Lower bound of the dwell, in cycles |
| dwell_max_i | input | DWELL_W | Upper bound of the dwell, in cycles |
| freq_code_o | output | CODE_W | Operating-point select code sent to the clock generator |
| freq_khz_o | output | KHZ_W | Nominal frequency of the selected point, in kHz |
| sample_idx_o | output | IDX_W | Sample counter, running once armed |
| log_valid_o | output | 1 | A change record is offered |
| log_ready_i | input | 1 | The consumer takes the record |
| log_index_o | output | IDX_W | Sample index at which the change took effect |
| log_code_o | output | CODE_W | Code selected by the change |

## Verification
The dwell-window property assumes two things about the inputs: `dwell_min_i` is not above `dwell_max_i`, and both stay steady in any cycle where a dwell is drawn. The stimulus changes the bounds only in the cycle a record appears, which is well before the next dwell draw, and it always sets them in that order. The entropy word carries no such assumption. The stimulus still chooses words that serve both the code draw and the dwell draw, so that every spacing between records can be worked out exactly. Rejections, invalid entropy and back-pressure are then brought in one at a time.

// File: rtl/hop_pkg.sv
// Package for the hopping controller: sequencer states and the mask helper.
// Assumes mask widths of at most 32 bits.
package hop_pkg;

    typedef enum logic [2:0] {
        HOP_IDLE  = 3'd0,
        HOP_CODE  = 3'd1,
        HOP_LOG   = 3'd2,
        HOP_DPICK = 3'd3,
        HOP_WAIT  = 3'd4
    } hop_state_t;

    // Returns the smallest value of the form 2^k-1 that is >= span.
    function automatic logic [31:0] cover_mask(input logic [31:0] span);
        logic [31:0] m;
        m = span;
        for (int s = 1; s < 32; s = s * 2) begin
            m = m | (m >> s);
        end
        return m;
    endfunction

endpackage

// File: rtl/hop_draw.sv
// Turns one entropy word into two candidates: an operating-point code and a
// dwell length. Each candidate comes with its own accept flag. Purely
// combinational. Assumes dmin <= dmax and RND_W >= CODE_W.
module hop_draw #(
    parameter int N_POINTS = 760,
    parameter int CODE_W   = 10,
    parameter int RND_W    = 16,
    parameter int DWELL_W  = 16
) (
    input  logic [RND_W-1:0]   rnd,
    input  logic [DWELL_W-1:0] dmin,
    input  logic [DWELL_W-1:0] dmax,
    output logic [CODE_W-1:0]  code_cand,
    output logic               code_ok,
    output logic [DWELL_W-1:0] dwell_val,
    output logic               dwell_ok
);
    import hop_pkg::*;

    logic [DWELL_W-1:0] span;
    logic [DWELL_W-1:0] mask;
    logic [DWELL_W-1:0] cand;

    // Code candidate: the low bits, kept only if they name a table entry.
    always_comb begin
        code_cand = rnd[CODE_W-1:0];
        code_ok   = int'(code_cand) < N_POINTS;
    end

    // Dwell candidate: masked to cover the window span, then range-tested.
    always_comb begin
        span      = dmax - dmin;
        mask      = DWELL_W'(cover_mask(32'(span)));
        cand      = DWELL_W'(rnd) & mask;
        dwell_ok  = cand <= span;
        dwell_val = dmin + cand;
    end

endmodule

// File: rtl/hop_timer.sv
// Down-counter for the dwell. It loads a length, counts down one per cycle
// while run is high, and flags when it reaches zero.
module hop_timer #(
    parameter int DWELL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DWELL_W-1:0] load_val,
    input  logic               run,
    output logic               zero
);
    logic [DWELL_W-1:0] cnt;

    // Counter: a load wins over a decrement; it stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - DWELL_W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/hop_optable.sv
// Maps an operating-point code to its nominal frequency in kHz. The points
// are evenly spaced, so the table is computed rather than stored.
module hop_optable #(
    parameter int CODE_W     = 10,
    parameter int KHZ_W      = 17,
    parameter int F_MIN_KHZ  = 5000,
    parameter int F_STEP_KHZ = 125
) (
    input  logic [CODE_W-1:0] code,
    output logic [KHZ_W-1:0]  khz
);
    // Linear mapping from code to frequency.
    always_comb begin
        khz = KHZ_W'(F_MIN_KHZ) + KHZ_W'(code) * KHZ_W'(F_STEP_KHZ);
    end

endmodule

// File: rtl/hop_freq_ctrl.sv
// Random frequency hopping controller. Once start_i arms it, it repeats the
// cycle draw code -> publish record -> draw dwell -> wait, and keeps a
// free-running sample index. Assumes the dwell bounds are stable while a
// dwell is drawn and that dwell_min_i <= dwell_max_i.
module hop_freq_ctrl #(
    parameter int N_POINTS   = 760,
    parameter int F_MIN_KHZ  = 5000,
    parameter int F_STEP_KHZ = 125,
    parameter int RND_W      = 16,
    parameter int DWELL_W    = 16,
    parameter int IDX_W      = 32,
    localparam int CODE_W    = $clog2(N_POINTS),
    localparam int KHZ_W     = $clog2(F_MIN_KHZ + F_STEP_KHZ * (N_POINTS - 1) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rnd_valid_i,
    input  logic [RND_W-1:0]   rnd_i,
    input  logic [DWELL_W-1:0] dwell_min_i,
    input  logic [DWELL_W-1:0] dwell_max_i,
    output logic [CODE_W-1:0]  freq_code_o,
    output logic [KHZ_W-1:0]   freq_khz_o,
    output logic [IDX_W-1:0]   sample_idx_o,
    output logic               log_valid_o,
    input  logic               log_ready_i,
    output logic [IDX_W-1:0]   log_index_o,
    output logic [CODE_W-1:0]  log_code_o
);
    import hop_pkg::*;

    hop_state_t          state;
    logic [CODE_W-1:0]   code_q;
    logic [IDX_W-1:0]    idx_q;
    logic [IDX_W-1:0]    rec_idx_q;
    logic                armed;
    logic [CODE_W-1:0]   code_cand;
    logic                code_ok;
    logic [DWELL_W-1:0]  tmr_val;
    logic                dwell_ok;
    logic                tmr_load;
    logic                tmr_zero;

    hop_draw #(
        .N_POINTS (N_POINTS),
        .CODE_W   (CODE_W),
        .RND_W    (RND_W),
        .DWELL_W  (DWELL_W)
    ) u_draw (
        .rnd       (rnd_i),
        .dmin      (dwell_min_i),
        .dmax      (dwell_max_i),
        .code_cand (code_cand),
        .code_ok   (code_ok),
        .dwell_val (tmr_val),
        .dwell_ok  (dwell_ok)
    );

    hop_timer #(
        .DWELL_W (DWELL_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (state == HOP_WAIT),
        .zero     (tmr_zero)
    );

    hop_optable #(
        .CODE_W     (CODE_W),
        .KHZ_W      (KHZ_W),
        .F_MIN_KHZ  (F_MIN_KHZ),
        .F_STEP_KHZ (F_STEP_KHZ)
    ) u_optable (
        .code (code_q),
        .khz  (freq_khz_o)
    );

    assign armed    = (state != HOP_IDLE);
    assign tmr_load = (state == HOP_DPICK) && rnd_valid_i && dwell_ok;

    // Sample index: held at zero while idle, one step per cycle once armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Hop sequencer: draws the code, holds the record, draws the dwell, waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= HOP_IDLE;
            code_q    <= '0;
            rec_idx_q <= '0;
        end else begin
            case (state)
                HOP_IDLE: begin
                    if (start_i) state <= HOP_CODE;
                end
                HOP_CODE: begin
                    if (rnd_valid_i && code_ok) begin
                        code_q    <= code_cand;
                        rec_idx_q <= idx_q + IDX_W'(1);
                        state     <= HOP_LOG;
                    end
                end
                HOP_LOG: begin
                    if (log_ready_i) state <= HOP_DPICK;
                end
                HOP_DPICK: begin
                    if (tmr_load) state <= HOP_WAIT;
                end
                HOP_WAIT: begin
                    if (tmr_zero) state <= HOP_CODE;
                end
                default: state <= HOP_IDLE;
            endcase
        end
    end

    assign freq_code_o  = code_q;
    assign sample_idx_o = idx_q;
    assign log_valid_o  = (state == HOP_LOG);
    assign log_index_o  = rec_idx_q;
    assign log_code_o   = code_q;

endmodule

// File: rtl/hop_freq_ctrl_chk.sv
// Checker for hop_freq_ctrl, attached with bind. It watches ports and a few
// internal nets. Assumes dwell bounds with min <= max that hold steady while
// a dwell is drawn.
module hop_freq_ctrl_chk #(
    parameter int N_POINTS = 760,
    parameter int CODE_W   = 10,
    parameter int DWELL_W  = 16,
    parameter int IDX_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               armed,
    input logic               rnd_valid,
    input logic [IDX_W-1:0]   sample_idx,
    input logic               log_valid,
    input logic               log_ready,
    input logic [IDX_W-1:0]   log_index,
    input logic [CODE_W-1:0]  log_code,
    input logic [CODE_W-1:0]  freq_code,
    input logic               tmr_load,
    input logic [DWELL_W-1:0] tmr_val,
    input logic [DWELL_W-1:0] dmin,
    input logic [DWELL_W-1:0] dmax
);
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!log_valid && sample_idx == '0));

    a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> sample_idx == $past(sample_idx) + IDX_W'(1));

    a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> int'(log_code) < N_POINTS);

    a_r5_index: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(log_valid) |-> log_index == sample_idx);

    a_r5_code_on_log: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_code) |-> $rose(log_valid));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid && !log_ready) |=> (log_valid && $stable(log_index) && $stable(log_code)));

    a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |-> (tmr_val >= dmin && tmr_val <= dmax));

    a_r8_no_draw: assert property (@(posedge clk) disable iff (!rst_n)
        !rnd_valid |=> $stable(freq_code));

endmodule

bind hop_freq_ctrl hop_freq_ctrl_chk #(
    .N_POINTS (N_POINTS),
    .CODE_W   (CODE_W),
    .DWELL_W  (DWELL_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed      (armed),
    .rnd_valid  (rnd_valid_i),
    .sample_idx (sample_idx_o),
    .log_valid  (log_valid_o),
    .log_ready  (log_ready_i),
    .log_index  (log_index_o),
    .log_code   (log_code_o),
    .freq_code  (freq_code_o),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .dmin       (dwell_min_i),
    .dmax       (dwell_max_i)
);

// File: tb/test_hop_freq_ctrl.sv
// Testbench for hop_freq_ctrl. A vector table is walked first, then directed
// tests cover rejection, back-pressure, invalid entropy and reset.
module test_hop_freq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rnd_valid_i = 1'b0;
    logic [15:0] rnd_i = '0;
    logic [15:0] dwell_min_i = '0;
    logic [15:0] dwell_max_i = '0;
    logic [9:0]  freq_code_o;
    logic [16:0] freq_khz_o;
    logic [31:0] sample_idx_o;
    logic        log_valid_o;
    logic        log_ready_i = 1'b1;
    logic [31:0] log_index_o;
    logic [9:0]  log_code_o;

    int tests = 0;
    int fails = 0;
    logic [31:0] prev_idx;
    logic [31:0] held_idx;
    logic        seen;

    always #10 clk = ~clk;

    hop_freq_ctrl i_hop_freq_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .rnd_valid_i  (rnd_valid_i),
        .rnd_i        (rnd_i),
        .dwell_min_i  (dwell_min_i),
        .dwell_max_i  (dwell_max_i),
        .freq_code_o  (freq_code_o),
        .freq_khz_o   (freq_khz_o),
        .sample_idx_o (sample_idx_o),
        .log_valid_o  (log_valid_o),
        .log_ready_i  (log_ready_i),
        .log_index_o  (log_index_o),
        .log_code_o   (log_code_o)
    );

    // Vector fields: entropy word, dwell min, dwell max, expected code, expected record spacing.
    localparam logic [95:0] VEC [6] = '{
        {16'h0003, 16'd2, 16'd9,     16'd3,   32'd0},
        {16'h02F7, 16'd0, 16'd1023,  16'd759, 32'd763},
        {16'hFC00, 16'd5, 16'd5,     16'd0,   32'd9},
        {16'h0012, 16'd10, 16'd40,   16'd18,  32'd32},
        {16'h8123, 16'd1, 16'hFFFF,  16'd291, 32'd33064},
        {16'h1200, 16'd3, 16'd3,     16'd512, 32'd7}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Waits at falling edges until a record is offered; gives up after a bound.
    task automatic wait_log();
        for (int n = 0; n < 40000; n++) begin
            @(negedge clk);
            if (log_valid_o) return;
        end
        check("R5 record timeout", 64'd0, 64'd1);
    endtask

    // Checks the record just offered, including the spacing from the previous one.
    task automatic check_rec(input logic [9:0] code, input logic [31:0] gap);
        check("R3 code", 64'(freq_code_o), 64'(code));
        check("R5 record code", 64'(log_code_o), 64'(code));
        check("R5 record index", 64'(log_index_o), 64'(sample_idx_o));
        check("R4 khz", 64'(freq_khz_o), 64'(5000 + 125 * int'(code)));
        if (gap != 0) check("R7 spacing", 64'(log_index_o - prev_idx), 64'(gap));
        prev_idx = log_index_o;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 code", 64'(freq_code_o), 64'd0);
        check("R1 index", 64'(sample_idx_o), 64'd0);
        check("R1 valid", 64'(log_valid_o), 64'd0);
        rst_n = 1'b1;

        // R2: idle before the trigger, even with entropy offered.
        rnd_valid_i = 1'b1;
        rnd_i       = VEC[0][95:80];
        dwell_min_i = VEC[0][79:64];
        dwell_max_i = VEC[0][63:48];
        repeat (8) @(negedge clk);
        check("R2 idle index", 64'(sample_idx_o), 64'd0);
        check("R2 idle valid", 64'(log_valid_o), 64'd0);
        check("R2 idle code", 64'(freq_code_o), 64'd0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 armed index", 64'(sample_idx_o), 64'd0);

        // Vector walk: R3 R4 R5 R7.
        for (int i = 0; i < 6; i++) begin
            wait_log();
            if (i == 0) check("R2 first index", 64'(sample_idx_o), 64'd1);
            check_rec(VEC[i][41:32], VEC[i][31:0]);
            if (i < 5) begin
                rnd_i       = VEC[i+1][95:80];
                dwell_min_i = VEC[i+1][79:64];
                dwell_max_i = VEC[i+1][63:48];
            end
        end

        // R3: codes 760 and up are rejected (the dwell part is valid).
        rnd_i = 16'h02F8; dwell_min_i = 16'd0; dwell_max_i = 16'hFFFF;
        seen = 1'b0;
        for (int n = 0; n < 900; n++) begin
            @(negedge clk);
            if (log_valid_o) seen = 1'b1;
        end
        check("R3 reject no record", 64'(seen), 64'd0);
        check("R3 reject code kept", 64'(freq_code_o), 64'd512);
        rnd_i = 16'h0001;
        wait_log();
        check_rec(10'd1, 32'd0);

        // R7: a dwell candidate above span is redrawn.
        rnd_i = 16'h0006; dwell_min_i = 16'd0; dwell_max_i = 16'd4;
        repeat (3) @(negedge clk);
        rnd_i = 16'h0002;
        wait_log();
        check_rec(10'd2, 32'd8);

        // R6: back-pressure holds the record and stalls the hop.
        log_ready_i = 1'b0;
        rnd_i = 16'h0005; dwell_min_i = 16'd0; dwell_max_i = 16'd0;
        held_idx = log_index_o;
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            check("R6 valid held", 64'(log_valid_o), 64'd1);
            check("R6 index held", 64'(log_index_o), 64'(held_idx));
            check("R6 code held", 64'(log_code_o), 64'd2);
        end
        check("R2 count", 64'(sample_idx_o), 64'(held_idx + 32'd6));
        log_ready_i = 1'b1;
        wait_log();
        check_rec(10'd5, 32'd10);

        // R8: invalid entropy draws nothing.
        rnd_valid_i = 1'b0;
        rnd_i = 16'h0009;
        seen = 1'b0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (log_valid_o && log_code_o != 10'd5) seen = 1'b1;
        end
        check("R8 no record", 64'(seen), 64'd0);
        check("R8 code kept", 64'(freq_code_o), 64'd5);
        rnd_valid_i = 1'b1;
        wait_log();
        check_rec(10'd9, 32'd23);

        // R1: reset while running, then R2: idle again without a trigger.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 rerun code", 64'(freq_code_o), 64'd0);
        check("R1 rerun index", 64'(sample_idx_o), 64'd0);
        check("R1 rerun valid", 64'(log_valid_o), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 rerun idle", 64'(sample_idx_o), 64'd0);
        check("R2 rerun code", 64'(freq_code_o), 64'd0);

        summary();
    end

endmodule